// File: doc/BRIEF.md
# Nested Interrupt Priority Arbiter

This block sits between a group of interrupt sources and the processor. Each source supplies a pending flag and an enable bit. It also supplies a three-bit group level and a two-bit tie-break level. Every cycle the arbiter looks at the sources that are both flagged and enabled. It picks one winner: the highest group first, then the highest tie-break level, then the lowest source index. The winner's index is the vector number shown to the processor.

The arbiter keeps a record of the interrupts currently in service. Each time the processor takes an interrupt, the level of that interrupt is pushed onto a small internal stack. Each time the processor returns from an interrupt, the stack is popped. A request goes out only when the winner strictly outranks the level on top of the stack. Because of this, nested handling works, and a return resumes at the level that was interrupted. Sources that lost arbitration keep their flags and compete again on every later cycle.

Top module: `irq_arbiter`

## Requirements
- R1: A source competes only when its flag is 1, its enable is 1 and its group level is not 0. A source with group level 0 never causes a request.
- R2: Among competing sources, the one with the numerically larger group level wins.
- R3: Among sources with the same group level, the one with the larger tie-break level (3 highest, 0 lowest) wins.
- R4: When sources are equal in both group and tie-break level, the lowest source index wins. `irq_vec` equals the index of the winner.
- R5: The request and vector outputs are registered. A change on the source inputs shows on `irq_req` at the first rising clock edge after the change, not before it. After reset, `irq_req` is 0, `svc_depth` is 0, and `svc_grp`/`svc_sub` are 0.
- R6: While an interrupt is in service, a competing source with a higher group level raises `irq_req`. A source with a lower group level does not.
- R7: While an interrupt is in service, a competing source in the same group raises `irq_req` only if its tie-break level is strictly larger. An equal or smaller tie-break level raises no request.
- R8: When `ack` is 1 while `irq_req` is 1 at a clock edge, the presented level becomes the in-service level (`svc_grp`, `svc_sub`). `svc_depth` also increments, and `irq_req` is 0 after that edge. When `ack` is 1 while `irq_req` is 0, nothing changes.
- R9: When `ret` is 1 at a clock edge with `svc_depth` above 0, the stack is popped. `svc_grp`/`svc_sub` go back to the level that was interrupted, or to 0 when the stack empties. Sources still pending are then presented again in the same order. `ret` takes priority over `ack` in the same cycle, and `ret` at depth 0 has no effect.
- R10: While the stack holds `DEPTH` levels, `irq_req` stays 0 whatever is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_flag | input | NSRC | Pending flag, one per source |
| src_en | input | NSRC | Enable, one per source |
| src_grp | input | 3*NSRC | Group level of source i in bits [3i+2:3i] |
| src_sub | input | 2*NSRC | Tie-break level of source i in bits [2i+1:2i] |
| ack | input | 1 | Processor takes the presented interrupt |
| ret | input | 1 | Processor returns from the current interrupt |
| irq_req | output | 1 | Request to the processor |
| irq_vec | output | clog2(NSRC) | Vector number (source index) of the request |
| irq_grp | output | 3 | Group level of the request |
| irq_sub | output | 2 | Tie-break level of the request |
| svc_grp | output | 3 | Group level in service (0 when idle) |
| svc_sub | output | 2 | Tie-break level in service |
| svc_depth | output | clog2(DEPTH+1) | Number of nested interrupts in service |

## Verification
The hardest state to reach is a full stack while a stronger source is pending. This state matters because request suppression must give way the moment a return frees a slot. The stimulus reaches it through four nested takes at rising group levels. It then raises a group-7 source and checks that no request appears. Finally it issues one return and checks that the group-7 request appears one cycle later. A second scenario covers a loser from an earlier arbitration. The loser stays flagged during a nested handler and must be presented once the handler returns and the stack empties.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int GRP_W = 3;
  localparam int SUB_W = 2;

  typedef struct packed {
    logic [GRP_W-1:0] grp;
    logic [SUB_W-1:0] sub;
  } lvl_t;

  localparam lvl_t LVL_IDLE = '{grp: '0, sub: '0};

  // strict ordering: group first, then tie-break level
  function automatic logic outranks(lvl_t a, lvl_t b);
    if (a.grp != b.grp) return a.grp > b.grp;
    return a.sub > b.sub;
  endfunction

  function automatic lvl_t make_lvl(logic [GRP_W-1:0] g, logic [SUB_W-1:0] s);
    lvl_t r;
    r.grp = g;
    r.sub = s;
    return r;
  endfunction

endpackage

// File: rtl/irq_arb_qual.sv
module irq_arb_qual
  import irq_arb_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic [NSRC-1:0]       flag,
  input  logic [NSRC-1:0]       en,
  input  logic [NSRC*GRP_W-1:0] grp_bus,
  input  logic [NSRC*SUB_W-1:0] sub_bus,
  output logic [NSRC-1:0]       elig,
  output lvl_t                  lvls [NSRC]
);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [GRP_W-1:0] g;
    logic [SUB_W-1:0] s;
    assign g       = grp_bus[i*GRP_W +: GRP_W];
    assign s       = sub_bus[i*SUB_W +: SUB_W];
    assign lvls[i] = make_lvl(g, s);
    // group level 0 is a mask
    assign elig[i] = flag[i] & en[i] & (g != '0);
  end

endmodule

// File: rtl/irq_arb_pick.sv
module irq_arb_pick
  import irq_arb_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] elig,
  input  lvl_t            lvls [NSRC],
  output logic            win_valid,
  output logic [IW-1:0]   win_idx,
  output lvl_t            win_lvl
);

  logic          stg_v [NSRC+1];
  logic [IW-1:0] stg_i [NSRC+1];
  lvl_t          stg_l [NSRC+1];

  assign stg_v[0] = 1'b0;
  assign stg_i[0] = '0;
  assign stg_l[0] = LVL_IDLE;

  // scan upward; a later index replaces only when strictly stronger,
  // so ties resolve to the lowest index
  for (genvar k = 0; k < NSRC; k++) begin : g_stage
    logic take;
    assign take         = elig[k] & (!stg_v[k] || outranks(lvls[k], stg_l[k]));
    assign stg_v[k+1]   = stg_v[k] | elig[k];
    assign stg_i[k+1]   = take ? IW'(k) : stg_i[k];
    assign stg_l[k+1]   = take ? lvls[k] : stg_l[k];
  end

  assign win_valid = stg_v[NSRC];
  assign win_idx   = stg_i[NSRC];
  assign win_lvl   = stg_l[NSRC];

endmodule

// File: rtl/irq_arb_stack.sv
module irq_arb_stack
  import irq_arb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  lvl_t          push_lvl,
  output lvl_t          top_lvl,
  output logic [DW-1:0] depth,
  output logic          full
);

  lvl_t          slot [DEPTH];
  logic [DW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == DW'(DEPTH));
  assign do_pop  = pop && (cnt != '0);
  assign do_push = push && !full && !pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= LVL_IDLE;
    end else begin
      if (do_pop) cnt <= cnt - 1'b1;
      else if (do_push) begin
        cnt <= cnt + 1'b1;
        for (int i = 0; i < DEPTH; i++)
          if (DW'(i) == cnt) slot[i] <= push_lvl;
      end
    end
  end

  always_comb begin
    top_lvl = LVL_IDLE;
    for (int i = 0; i < DEPTH; i++)
      if (DW'(i + 1) == cnt) top_lvl = slot[i];
  end

  assign depth = cnt;

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= DW'(DEPTH));

  // R9
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt == '0) |=> cnt == '0);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int DEPTH = 4,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       src_flag,
  input  logic [NSRC-1:0]       src_en,
  input  logic [NSRC*GRP_W-1:0] src_grp,
  input  logic [NSRC*SUB_W-1:0] src_sub,
  input  logic                  ack,
  input  logic                  ret,
  output logic                  irq_req,
  output logic [IW-1:0]         irq_vec,
  output logic [GRP_W-1:0]      irq_grp,
  output logic [SUB_W-1:0]      irq_sub,
  output logic [GRP_W-1:0]      svc_grp,
  output logic [SUB_W-1:0]      svc_sub,
  output logic [DW-1:0]         svc_depth
);

  logic [NSRC-1:0] elig;
  lvl_t            lvls [NSRC];
  logic            win_valid;
  logic [IW-1:0]   win_idx;
  lvl_t            win_lvl;
  lvl_t            cur_lvl;
  logic            stk_full;
  logic [DW-1:0]   depth_w;

  // named internal events
  logic preempt_w;
  logic ack_take;
  logic ret_take;

  lvl_t          req_lvl_q;
  logic          req_q;
  logic [IW-1:0] vec_q;

  irq_arb_qual #(.NSRC(NSRC)) u_qual (
    .flag    (src_flag),
    .en      (src_en),
    .grp_bus (src_grp),
    .sub_bus (src_sub),
    .elig    (elig),
    .lvls    (lvls)
  );

  irq_arb_pick #(.NSRC(NSRC)) u_pick (
    .elig      (elig),
    .lvls      (lvls),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  assign ret_take = ret && (depth_w != '0);
  assign ack_take = ack && req_q && !ret;

  irq_arb_stack #(.DEPTH(DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ack_take),
    .pop      (ret_take),
    .push_lvl (req_lvl_q),
    .top_lvl  (cur_lvl),
    .depth    (depth_w),
    .full     (stk_full)
  );

  // idle level is {0,0}; any eligible source has group >= 1 and outranks it
  assign preempt_w = win_valid && !stk_full && outranks(win_lvl, cur_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      vec_q     <= '0;
      req_lvl_q <= LVL_IDLE;
    end else begin
      req_q     <= preempt_w && !ack_take;
      vec_q     <= win_idx;
      req_lvl_q <= win_lvl;
    end
  end

  assign irq_req   = req_q;
  assign irq_vec   = vec_q;
  assign irq_grp   = req_lvl_q.grp;
  assign irq_sub   = req_lvl_q.sub;
  assign svc_grp   = cur_lvl.grp;
  assign svc_sub   = cur_lvl.sub;
  assign svc_depth = depth_w;

  // R1
  masked_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_grp != '0);

  // R6 R7
  preempt_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> outranks(make_lvl(irq_grp, irq_sub), $past(cur_lvl)));

  // R8
  ack_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> (svc_depth == DW'($past(svc_depth) + 1'b1)) && !irq_req);

  // R9
  ret_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_take |=> svc_depth == DW'($past(svc_depth) - 1'b1));

  // R10
  full_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full |-> !irq_req);

  // R8
  svc_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_depth != '0) |-> (svc_grp != '0));

endmodule

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;

  localparam int N = 8;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] flag, en;
  logic [2:0] grp [N];
  logic [1:0] sub [N];
  logic [N*3-1:0] grp_bus;
  logic [N*2-1:0] sub_bus;
  logic ack = 1'b0, ret = 1'b0;
  logic irq_req;
  logic [2:0] irq_vec;
  logic [2:0] irq_grp, svc_grp;
  logic [1:0] irq_sub, svc_sub;
  logic [2:0] svc_depth;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      grp_bus[i*3 +: 3] = grp[i];
      sub_bus[i*2 +: 2] = sub[i];
    end
  end

  irq_arbiter #(.NSRC(N), .DEPTH(D)) i_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .src_flag(flag), .src_en(en),
    .src_grp(grp_bus), .src_sub(sub_bus), .ack(ack), .ret(ret),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_grp(irq_grp), .irq_sub(irq_sub),
    .svc_grp(svc_grp), .svc_sub(svc_sub), .svc_depth(svc_depth)
  );

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_src();
    flag = '0;
    en   = '0;
    for (int i = 0; i < N; i++) begin
      grp[i] = 3'd0;
      sub[i] = 2'd0;
    end
  endtask

  task automatic set_src(int i, int g, int s);
    flag[i] = 1'b1;
    en[i]   = 1'b1;
    grp[i]  = 3'(g);
    sub[i]  = 2'(s);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ack = 1'b0;
    ret = 1'b0;
    clear_src();
    step();
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic take();
    ack = 1'b1;
    step();
    ack = 1'b0;
  endtask

  task automatic leave();
    ret = 1'b1;
    step();
    ret = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R5", "reset req", irq_req, 0);
    check("R5", "reset depth", svc_depth, 0);
    check("R5", "reset svc_grp", svc_grp, 0);
  endtask

  task automatic t_qualify();
    do_reset();
    flag[1] = 1'b1; grp[1] = 3'd5;      // enable low
    step(); step();
    check("R1", "disabled source req", irq_req, 0);
    en[1] = 1'b1; grp[1] = 3'd0;        // group 0 mask
    step(); step();
    check("R1", "group 0 source req", irq_req, 0);
    ack = 1'b1; step(); ack = 1'b0;     // ack without request: no effect
    check("R8", "ack without req depth", svc_depth, 0);
    grp[1] = 3'd2;
    step();
    check("R1", "qualified source req", irq_req, 1);
    check("R4", "qualified source vec", irq_vec, 1);
  endtask

  task automatic t_latency();
    do_reset();
    set_src(3, 2, 0);
    #1;
    check("R5", "req before edge", irq_req, 0);
    step();
    check("R5", "req after one edge", irq_req, 1);
    check("R5", "vec after one edge", irq_vec, 3);
  endtask

  task automatic t_order();
    do_reset();
    set_src(2, 3, 3);
    set_src(5, 6, 0);
    step();
    check("R2", "higher group wins", irq_vec, 5);
    check("R2", "winner group", irq_grp, 6);
    clear_src();
    set_src(1, 4, 1);
    set_src(6, 4, 2);
    step();
    check("R3", "higher sub wins", irq_vec, 6);
    check("R3", "winner sub", irq_sub, 2);
    clear_src();
    set_src(4, 5, 1);
    set_src(2, 5, 1);
    set_src(7, 5, 1);
    step();
    check("R4", "tie lowest index", irq_vec, 2);
  endtask

  task automatic t_preempt();
    do_reset();
    set_src(0, 4, 1);
    step();
    take();
    check("R8", "depth after ack", svc_depth, 1);
    check("R8", "svc_grp after ack", svc_grp, 4);
    check("R8", "svc_sub after ack", svc_sub, 1);
    check("R8", "req drops after ack", irq_req, 0);
    set_src(3, 4, 1);
    step(); step();
    check("R7", "equal level no preempt", irq_req, 0);
    set_src(5, 3, 3);
    step(); step();
    check("R6", "lower group no preempt", irq_req, 0);
    set_src(6, 4, 2);
    step();
    check("R7", "higher sub preempts", irq_req, 1);
    check("R7", "higher sub vec", irq_vec, 6);
    flag[6] = 1'b0;
    set_src(7, 6, 0);
    step();
    check("R6", "higher group preempts", irq_req, 1);
    check("R6", "higher group vec", irq_vec, 7);
  endtask

  task automatic t_full();
    do_reset();
    for (int k = 0; k < D; k++) begin
      set_src(k, k + 1, 0);
      step();
      take();
    end
    check("R10", "stack depth full", svc_depth, D);
    set_src(4, 7, 0);
    step(); step();
    check("R10", "no req when full", irq_req, 0);
    leave();
    check("R9", "depth after ret", svc_depth, D - 1);
    check("R9", "restored group", svc_grp, 3);
    step();
    check("R10", "req after slot freed", irq_req, 1);
    check("R10", "vec after slot freed", irq_vec, 4);
  endtask

  task automatic t_resume();
    do_reset();
    set_src(2, 3, 0);
    set_src(5, 6, 0);
    step();
    take();
    check("R9", "svc group 6", svc_grp, 6);
    step();
    check("R9", "loser held while in service", irq_req, 0);
    flag[5] = 1'b0;
    ret = 1'b1; ack = 1'b1;             // ret wins over ack
    step();
    ret = 1'b0; ack = 1'b0;
    check("R9", "depth 0 after ret", svc_depth, 0);
    check("R9", "svc_grp idle", svc_grp, 0);
    step();
    check("R9", "loser presented", irq_req, 1);
    check("R9", "loser vec", irq_vec, 2);
    leave();
    check("R9", "ret at depth 0", svc_depth, 0);
  endtask

  initial begin
    clear_src();
    t_reset();
    t_qualify();
    t_latency();
    t_order();
    t_preempt();
    t_full();
    t_resume();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule